// File: doc/BRIEF.md
# Label Stack Editor for a Switched Label Path

This block edits the label stack of packets that arrive as a stream of 32-bit words framed by start and end flags. The first word holds sixteen unused bits and then a 16-bit type code. On a labelled packet the stack entries come straight after the type. The block keeps the first two words: the type word and the top stack entry. It reads the top entry's 20-bit label and sends it as the address of one read to an external read-only lookup memory, 64 bits wide. While that read is outstanding the input is held off.

The memory word gives an operation and up to three new labels. The block can replace the top label, put one, two or three new entries in front of the stack, replace the top label and then put one entry in front, or take the top entry off. It then sends out the edited packet on a valid/ready output. Inserted entries make the packet longer, by at most three words. A removed entry makes it one word shorter. Every forwarded labelled packet takes the decremented TTL on exactly one entry, or on the inner IPv4 header after a pop of the last entry. A packet whose TTL would reach zero is dropped without a lookup. A packet of any other type passes through unchanged.

Top module: `mpls_label_editor`

## Requirements
- R1: A packet whose type code (bits 15:0 of its first word) is not 0x8847 is sent out word for word unchanged, and no lookup is issued for it. After reset, in_ready is 1 and out_valid and lk_req are 0.
- R2: On a labelled packet, the top entry is laid out as label in bits 31:12, class of service in bits 11:9, bottom flag S in bit 8 and TTL in bits 7:0. The outgoing TTL is the TTL minus one. If the top TTL is 0 or 1, the whole packet is consumed and nothing is sent out, and no lookup is issued.
- R3: Each live labelled packet issues exactly one lk_req pulse, with lk_addr equal to the top label. in_ready stays 0 from that pulse until lk_rvalid. The result word is read as follows: operation code in bits 63:60, label A in bits 19:0, label B in bits 39:20 and label C in bits 59:40.
- R4: Operation 1 (swap) rewrites the top entry. It gets label A and the outgoing TTL, and keeps its class of service and S.
- R5: Operation 2 puts one entry directly after the type word: label A, the copied class of service, S=0 and the outgoing TTL. The old top entry follows it unchanged.
- R6: Operation 3 puts two entries after the type word. The first has label B and the outgoing TTL. The second has label A and TTL 255. Both have S=0 and the copied class of service. The old top entry follows unchanged.
- R7: Operation 4 puts three entries after the type word, with labels C, B and A in that order. Only the first carries the outgoing TTL; the other two carry 255. All three have S=0 and the copied class of service.
- R8: Operation 5 sends the type word, then a new entry, then the rewritten top entry. The new entry has label A, TTL 255, S=0 and the copied class of service. The rewritten top entry has label B and the outgoing TTL, and keeps its class of service and S.
- R9: Operation 6 with S=0 removes the top entry. The outgoing TTL is written into bits 7:0 of the word that followed it.
- R10: Operation 6 with S=1 removes the top entry and changes the type code to 0x0800. It writes the outgoing TTL into bits 31:24 of the third word after the removed entry, which is the IPv4 TTL byte.
- R11: Any other operation code (0 or 7 to 15) drops the packet, and nothing is sent out.
- R12: While out_valid is 1 and out_ready is 0, the output word and flags hold. out_sop marks only the first word sent and out_eop marks only the last.
- R13: A labelled packet that ends on its first word passes unchanged with no lookup. One that ends on its second word is edited and ends on its last header word. A word that arrives between packets without a start flag is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_sop | output | 1 | First output word of a packet |
| out_eop | output | 1 | Last output word of a packet |
| out_data | output | 32 | Output word |
| lk_req | output | 1 | One-cycle lookup read request |
| lk_addr | output | 20 | Lookup address (top label) |
| lk_rvalid | input | 1 | Lookup result valid |
| lk_rdata | input | 64 | Lookup result word |

## Verification
The bench builds the block with its default parameters: 32-bit words, 20-bit labels, a 64-bit result and a five-word header window. The lookup memory model takes the operation code from the top four bits of the address, so each label the bench chooses selects a known operation. The sweep covers all sixteen codes' classes: every valid operation, the invalid codes 0 and 7, TTL values 0, 1, 2, 200 and 255, both S values and packet lengths of 2, 3 and 6 words. It adds single-word packets, foreign types and a stray word. The whole sweep runs once with the output always ready and once under pseudo-random back-pressure, so that held header words and body words stalled in flight are both exercised.

// File: rtl/mpls_edit_pkg.sv
package mpls_edit_pkg;
  localparam int WORD_W  = 32;
  localparam int LABEL_W = 20;
  localparam int RES_W   = 64;
  localparam int MAX_HDR = 5;
  localparam int HCNT_W  = $clog2(MAX_HDR + 1);

  localparam logic [15:0] TYPE_MPLS = 16'h8847;
  localparam logic [15:0] TYPE_IPV4 = 16'h0800;

  localparam logic [3:0] OP_SWAP   = 4'd1;
  localparam logic [3:0] OP_PUSH1  = 4'd2;
  localparam logic [3:0] OP_PUSH2  = 4'd3;
  localparam logic [3:0] OP_PUSH3  = 4'd4;
  localparam logic [3:0] OP_SWPUSH = 4'd5;
  localparam logic [3:0] OP_POP    = 4'd6;

  typedef enum logic [1:0] {
    PATCH_NONE,
    PATCH_INNER_TTL,
    PATCH_IP_TTL
  } patch_e;

  function automatic logic [WORD_W-1:0] mk_entry(input logic [LABEL_W-1:0] lbl,
                                                 input logic [2:0] cos,
                                                 input logic s,
                                                 input logic [7:0] ttl);
    return {lbl, cos, s, ttl};
  endfunction

  function automatic logic [LABEL_W-1:0] ent_label(input logic [WORD_W-1:0] e);
    return e[31:12];
  endfunction

  function automatic logic [2:0] ent_cos(input logic [WORD_W-1:0] e);
    return e[11:9];
  endfunction

  function automatic logic ent_bottom(input logic [WORD_W-1:0] e);
    return e[8];
  endfunction

  function automatic logic [7:0] ent_ttl(input logic [WORD_W-1:0] e);
    return e[7:0];
  endfunction

  function automatic logic ttl_alive(input logic [7:0] ttl);
    return ttl > 8'd1;
  endfunction

  function automatic logic [7:0] ttl_next(input logic [7:0] ttl);
    return ttl - 8'd1;
  endfunction

  function automatic logic [3:0] res_op(input logic [RES_W-1:0] r);
    return r[63:60];
  endfunction

  function automatic logic [LABEL_W-1:0] res_label(input logic [RES_W-1:0] r,
                                                   input int k);
    case (k)
      1:       return r[19:0];
      2:       return r[39:20];
      default: return r[59:40];
    endcase
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    return (op >= OP_SWAP) && (op <= OP_POP);
  endfunction
endpackage

// File: rtl/mpls_edit_plan.sv
module mpls_edit_plan
  import mpls_edit_pkg::*;
(
  input  logic                           is_mpls,
  input  logic [WORD_W-1:0]              w0,
  input  logic [WORD_W-1:0]              top,
  input  logic [RES_W-1:0]               res,
  output logic [MAX_HDR-1:0][WORD_W-1:0] hdr_words,
  output logic [HCNT_W-1:0]              hdr_cnt,
  output patch_e                         patch,
  output logic [7:0]                     out_ttl
);
  logic [2:0]         cos;
  logic               bot;
  logic [LABEL_W-1:0] lab_a, lab_b, lab_c;

  assign cos     = ent_cos(top);
  assign bot     = ent_bottom(top);
  assign out_ttl = ttl_next(ent_ttl(top));
  assign lab_a   = res_label(res, 1);
  assign lab_b   = res_label(res, 2);
  assign lab_c   = res_label(res, 3);

  always_comb begin
    hdr_words    = '0;
    hdr_words[0] = w0;
    hdr_cnt      = HCNT_W'(1);
    patch        = PATCH_NONE;
    if (is_mpls) begin
      case (res_op(res))
        OP_SWAP: begin
          hdr_words[1] = mk_entry(lab_a, cos, bot, out_ttl);
          hdr_cnt      = HCNT_W'(2);
        end
        OP_PUSH1: begin
          hdr_words[1] = mk_entry(lab_a, cos, 1'b0, out_ttl);
          hdr_words[2] = top;
          hdr_cnt      = HCNT_W'(3);
        end
        OP_PUSH2: begin
          hdr_words[1] = mk_entry(lab_b, cos, 1'b0, out_ttl);
          hdr_words[2] = mk_entry(lab_a, cos, 1'b0, 8'd255);
          hdr_words[3] = top;
          hdr_cnt      = HCNT_W'(4);
        end
        OP_PUSH3: begin
          hdr_words[1] = mk_entry(lab_c, cos, 1'b0, out_ttl);
          hdr_words[2] = mk_entry(lab_b, cos, 1'b0, 8'd255);
          hdr_words[3] = mk_entry(lab_a, cos, 1'b0, 8'd255);
          hdr_words[4] = top;
          hdr_cnt      = HCNT_W'(5);
        end
        OP_SWPUSH: begin
          hdr_words[1] = mk_entry(lab_a, cos, 1'b0, 8'd255);
          hdr_words[2] = mk_entry(lab_b, cos, bot, out_ttl);
          hdr_cnt      = HCNT_W'(3);
        end
        OP_POP: begin
          if (bot) begin
            hdr_words[0] = {w0[31:16], TYPE_IPV4};
            patch        = PATCH_IP_TTL;
          end else begin
            patch        = PATCH_INNER_TTL;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mpls_body_patch.sv
module mpls_body_patch
  import mpls_edit_pkg::*;
#(
  parameter int IDX_W     = 2,
  parameter int INNER_IDX = 0,
  parameter int IP_IDX    = 2
) (
  input  logic [WORD_W-1:0] in_word,
  input  logic [IDX_W-1:0]  idx,
  input  patch_e            mode,
  input  logic [7:0]        ttl,
  output logic [WORD_W-1:0] out_word
);
  always_comb begin
    out_word = in_word;
    if (mode == PATCH_INNER_TTL && idx == IDX_W'(INNER_IDX))
      out_word[7:0] = ttl;
    else if (mode == PATCH_IP_TTL && idx == IDX_W'(IP_IDX))
      out_word[31:24] = ttl;
  end
endmodule

// File: rtl/mpls_label_editor.sv
module mpls_label_editor
  import mpls_edit_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [WORD_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_sop,
  output logic               out_eop,
  output logic [WORD_W-1:0]  out_data,
  output logic               lk_req,
  output logic [LABEL_W-1:0] lk_addr,
  input  logic               lk_rvalid,
  input  logic [RES_W-1:0]   lk_rdata
);
  localparam int BIDX_W = 2;

  typedef enum logic [2:0] {
    S_W0, S_W1, S_LREQ, S_LWAIT, S_EMIT, S_BODY, S_DROP
  } state_e;

  state_e                         state;
  logic [WORD_W-1:0]              w0_q, top_q;
  logic [RES_W-1:0]               res_q;
  logic                           mpls_q, hdr_eop_q;
  logic [HCNT_W-1:0]              hidx;
  logic [BIDX_W-1:0]              bidx;
  logic [MAX_HDR-1:0][WORD_W-1:0] hdr_words;
  logic [HCNT_W-1:0]              hdr_cnt;
  patch_e                         patch;
  logic [7:0]                     out_ttl;
  logic [WORD_W-1:0]              body_word;

  logic in_fire, out_fire, last_hdr;
  logic emit_phase, drop_phase;

  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign last_hdr   = (hidx == hdr_cnt - HCNT_W'(1));
  assign emit_phase = (state == S_EMIT);
  assign drop_phase = (state == S_DROP);
  assign lk_addr    = ent_label(top_q);

  mpls_edit_plan u_plan (
    .is_mpls   (mpls_q),
    .w0        (w0_q),
    .top       (top_q),
    .res       (res_q),
    .hdr_words (hdr_words),
    .hdr_cnt   (hdr_cnt),
    .patch     (patch),
    .out_ttl   (out_ttl)
  );

  mpls_body_patch #(.IDX_W(BIDX_W)) u_patch (
    .in_word  (in_data),
    .idx      (bidx),
    .mode     (patch),
    .ttl      (out_ttl),
    .out_word (body_word)
  );

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    out_data  = hdr_words[hidx];
    lk_req    = 1'b0;
    case (state)
      S_W0, S_W1, S_DROP: in_ready = 1'b1;
      S_LREQ:             lk_req   = 1'b1;
      S_EMIT: begin
        out_valid = 1'b1;
        out_sop   = (hidx == '0);
        out_eop   = hdr_eop_q && last_hdr;
      end
      S_BODY: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_eop   = in_eop;
        out_data  = body_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_W0;
      w0_q      <= '0;
      top_q     <= '0;
      res_q     <= '0;
      mpls_q    <= 1'b0;
      hdr_eop_q <= 1'b0;
      hidx      <= '0;
      bidx      <= '0;
    end else begin
      case (state)
        S_W0: if (in_fire && in_sop) begin
          w0_q      <= in_data;
          hdr_eop_q <= in_eop;
          hidx      <= '0;
          mpls_q    <= (in_data[15:0] == TYPE_MPLS) && !in_eop;
          if (in_data[15:0] == TYPE_MPLS && !in_eop) state <= S_W1;
          else                                      state <= S_EMIT;
        end
        S_W1: if (in_fire) begin
          top_q     <= in_data;
          hdr_eop_q <= in_eop;
          if (ttl_alive(ent_ttl(in_data))) state <= S_LREQ;
          else if (in_eop)                 state <= S_W0;
          else                             state <= S_DROP;
        end
        S_LREQ: state <= S_LWAIT;
        S_LWAIT: if (lk_rvalid) begin
          res_q <= lk_rdata;
          if (op_known(res_op(lk_rdata))) state <= S_EMIT;
          else if (hdr_eop_q)             state <= S_W0;
          else                            state <= S_DROP;
        end
        S_EMIT: if (out_fire) begin
          if (last_hdr) begin
            bidx  <= '0;
            state <= hdr_eop_q ? S_W0 : S_BODY;
          end else begin
            hidx <= hidx + HCNT_W'(1);
          end
        end
        S_BODY: if (in_fire) begin
          if (bidx != '1) bidx <= bidx + BIDX_W'(1);
          if (in_eop) state <= S_W0;
        end
        S_DROP: if (in_fire && in_eop) state <= S_W0;
        default: state <= S_W0;
      endcase
    end
  end
endmodule

// File: rtl/mpls_editor_chk.sv
module mpls_editor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_req,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_eop,
  input logic [31:0] out_data,
  input logic        emit_phase,
  input logic        drop_phase
);
  a_r3_input_held_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> !in_ready);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> !lk_req);

  a_r3_no_output_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> !out_valid);

  a_r12_header_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_phase && out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_eop)));

  a_r2_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    drop_phase |-> !out_valid);
endmodule

bind mpls_label_editor mpls_editor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_req     (lk_req),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_eop    (out_eop),
  .out_data   (out_data),
  .emit_phase (emit_phase),
  .drop_phase (drop_phase)
);

// File: tb/mpls_label_editor_tb.sv
`timescale 1ns/1ps
module mpls_label_editor_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        in_valid, in_ready, in_sop, in_eop;
  logic [31:0] in_data;
  logic        out_valid, out_ready, out_sop, out_eop;
  logic [31:0] out_data;
  logic        lk_req, lk_rvalid;
  logic [19:0] lk_addr;
  logic [63:0] lk_rdata;

  mpls_label_editor u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_rvalid(lk_rvalid), .lk_rdata(lk_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit bp_en = 0;

  // Lookup memory model: op code from address bits 19:16
  function automatic logic [63:0] lk_model(input logic [19:0] a);
    logic [19:0] la, lb, lc;
    la = a ^ 20'h5A5A5;
    lb = a + 20'd7;
    lc = {a[9:0], a[19:10]};
    return {a[19:16], lc, lb, la};
  endfunction

  logic [1:0]  lk_pipe;
  logic [19:0] lk_a1;
  int          lk_cnt;
  logic [7:0]  lfsr;

  always @(posedge clk) begin
    if (!rst_n) begin
      lk_pipe <= '0;
      lk_a1   <= '0;
      lk_cnt  <= 0;
      lfsr    <= 8'h5B;
      out_ready <= 1'b1;
    end else begin
      lk_pipe <= {lk_pipe[0], lk_req};
      if (lk_req) begin
        lk_a1  <= lk_addr;
        lk_cnt <= lk_cnt + 1;
      end
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready <= bp_en ? lfsr[0] : 1'b1;
    end
  end
  assign lk_rvalid = lk_pipe[1];
  assign lk_rdata  = lk_model(lk_a1);

  logic [31:0] got [0:15];
  logic        gs  [0:15];
  logic        ge  [0:15];
  int          got_n;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && got_n < 16) begin
      got[got_n] = out_data;
      gs[got_n]  = out_sop;
      ge[got_n]  = out_eop;
      got_n++;
    end
  end

  logic [31:0] pin [0:7];
  int          plen;
  logic [31:0] ex  [0:15];
  int          ex_n;
  int          ex_lk;
  string       tag;

  function automatic logic [31:0] ent(input logic [19:0] l, input logic [2:0] c,
                                      input logic s, input logic [7:0] t);
    return {l, c, s, t};
  endfunction

  task automatic build_expected();
    logic [31:0] top;
    logic [63:0] r;
    logic [7:0]  ot;
    logic [2:0]  c;
    logic        s;
    logic [3:0]  op;
    int          k;
    ex_n  = 0;
    ex_lk = 0;
    if (pin[0][15:0] != 16'h8847 || plen == 1) begin
      tag = (plen == 1 && pin[0][15:0] == 16'h8847) ? "R13" : "R1";
      for (int i = 0; i < plen; i++) ex[i] = pin[i];
      ex_n = plen;
      return;
    end
    top = pin[1];
    if (top[7:0] <= 8'd1) begin
      tag = "R2";
      return;
    end
    ex_lk = 1;
    r  = lk_model(top[31:12]);
    op = r[63:60];
    ot = top[7:0] - 8'd1;
    c  = top[11:9];
    s  = top[8];
    ex[0] = pin[0];
    k = 1;
    case (op)
      4'd1: begin tag = "R4"; ex[1] = ent(r[19:0], c, s, ot); k = 2; end
      4'd2: begin tag = "R5"; ex[1] = ent(r[19:0], c, 1'b0, ot); ex[2] = top; k = 3; end
      4'd3: begin
        tag = "R6";
        ex[1] = ent(r[39:20], c, 1'b0, ot);
        ex[2] = ent(r[19:0], c, 1'b0, 8'hFF);
        ex[3] = top; k = 4;
      end
      4'd4: begin
        tag = "R7";
        ex[1] = ent(r[59:40], c, 1'b0, ot);
        ex[2] = ent(r[39:20], c, 1'b0, 8'hFF);
        ex[3] = ent(r[19:0], c, 1'b0, 8'hFF);
        ex[4] = top; k = 5;
      end
      4'd5: begin
        tag = "R8";
        ex[1] = ent(r[19:0], c, 1'b0, 8'hFF);
        ex[2] = ent(r[39:20], c, s, ot); k = 3;
      end
      4'd6: begin
        tag = s ? "R10" : "R9";
        if (s) ex[0] = {pin[0][31:16], 16'h0800};
        k = 1;
      end
      default: begin tag = "R11"; return; end
    endcase
    for (int i = 2; i < plen; i++) begin
      logic [31:0] w;
      w = pin[i];
      if (op == 4'd6 && !s && i == 2) w[7:0] = ot;
      if (op == 4'd6 && s && i == 4) w[31:24] = ot;
      ex[k] = w;
      k++;
    end
    ex_n = k;
  endtask

  task automatic send_pkt(input bit with_sop);
    int lk0;
    bit ok;
    int bad;
    got_n = 0;
    lk0 = lk_cnt;
    for (int i = 0; i < plen; i++) begin
      in_valid = 1'b1;
      in_data  = pin[i];
      in_sop   = with_sop && (i == 0);
      in_eop   = (i == plen - 1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
    repeat (30) @(posedge clk);
    #1;
    if (with_sop) build_expected();
    else begin tag = "R13"; ex_n = 0; ex_lk = 0; end
    ok  = (got_n == ex_n);
    bad = -1;
    for (int i = 0; i < got_n && ok; i++) begin
      if (got[i] !== ex[i] || gs[i] !== (i == 0) || ge[i] !== (i == got_n - 1)) begin
        ok = 0; bad = i;
      end
    end
    n_chk++;
    if (!ok) begin
      n_fail++;
      if (bad < 0)
        $display("FAIL %s: word count actual %0d expected %0d", tag, got_n, ex_n);
      else
        $display("FAIL %s: word %0d actual %h sop%0b eop%0b expected %h", tag, bad,
                 got[bad], gs[bad], ge[bad], ex[bad]);
    end
    n_chk++;
    if ((lk_cnt - lk0) != ex_lk) begin
      n_fail++;
      $display("FAIL R3 (%s): lookups actual %0d expected %0d", tag, lk_cnt - lk0, ex_lk);
    end
    if (ex_lk == 1) begin
      n_chk++;
      if (lk_a1 !== pin[1][31:12]) begin
        n_fail++;
        $display("FAIL R3: lk_addr actual %h expected %h", lk_a1, pin[1][31:12]);
      end
    end
  endtask

  task automatic fill_body(input int id);
    for (int i = 2; i < 8; i++)
      pin[i] = {8'(id), 8'(i), 16'hC0DE ^ 16'(id * 13)};
  endtask

  task automatic sweep();
    int ttls [0:4] = '{0, 1, 2, 200, 255};
    int lens [0:2] = '{2, 3, 6};
    int id = 0;
    for (int op = 0; op < 8; op++)
      for (int t = 0; t < 5; t++)
        for (int s = 0; s < 2; s++)
          for (int l = 0; l < 3; l++) begin
            id++;
            plen   = lens[l];
            pin[0] = {16'(id * 7), 16'h8847};
            pin[1] = {4'(op), 16'(id * 37), 3'(id), 1'(s), 8'(ttls[t])};
            fill_body(id);
            send_pkt(1'b1);
          end
    // foreign types and single-word packets
    for (int l = 1; l < 5; l++) begin
      plen   = l;
      pin[0] = {16'hBEEF, 16'h0800};
      pin[1] = 32'h4D000000 | 32'(l);
      fill_body(l + 500);
      send_pkt(1'b1);
      pin[0] = {16'h1357, 16'h1234};
      send_pkt(1'b1);
    end
    plen   = 1;
    pin[0] = {16'h0000, 16'h8847};
    send_pkt(1'b1);
    // stray word with no start flag
    plen   = 1;
    pin[0] = {16'h7777, 16'h1234};
    send_pkt(1'b0);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
    in_data  = '0;
    got_n    = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || lk_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset out_valid %b in_ready %b lk_req %b expected 0 1 0",
               out_valid, in_ready, lk_req);
    end
    @(posedge clk); #1;
    bp_en = 0;
    sweep();
    bp_en = 1;
    sweep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule